// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block works out the next program counter for an 8-bit processor's control-transfer instructions. The decoder hands it the kind of transfer, a 3-bit condition field, the four status flags, a 16-bit target, the HL pair, the fall-through address (the address of the instruction after the transfer) and the stack pointer. The block then raises a single-cycle `done` strobe with the new PC and SP.

Jumps, jumps through HL and transfers whose condition fails finish in one cycle. Calls, restarts and returns whose condition holds run a two-byte sequence on a byte-wide stack memory port. That port has a combinational read: read data must be valid in the same cycle that `mem_rd` is high. While such a sequence runs, `busy` is high and any new `start` is dropped.

Top module: `pc_branch_unit`

## Requirements
- R1: While reset is held, and on the first sample after it is released, `done`, `busy`, `mem_wr` and `mem_rd` are 0, and `pc_next` and `sp_next` are 0.
- R2: A condition is true when the flag picked by `cond[2:1]` equals `cond[0]`. The picks are 00 zero, 01 carry, 10 parity, 11 sign. So the codes 0 to 7 mean not-zero, zero, no-carry, carry, parity odd, parity even, plus and minus.
- R3: A jump (`op`=0) finishes with `done` one cycle after `start`. If `cond_en` is 0 or the condition is true, `pc_next` is the target. Otherwise `pc_next` is `pc_in`. In both cases `sp_next` is `sp_in` and the stack port is never accessed.
- R4: A call (`op`=1) whose condition holds writes `pc_in[15:8]` at SP-1 and then `pc_in[7:0]` at SP-2, one byte per cycle, high byte first. It finishes three cycles after `start` with `pc_next` = target and `sp_next` = SP-2.
- R5: A return (`op`=2) whose condition holds reads the low byte at SP and then the high byte at SP+1. It finishes three cycles after `start` with `pc_next` = {high,low} and `sp_next` = SP+2.
- R6: A conditional call or return whose condition is false finishes one cycle after `start`. It makes no stack access and gives `pc_next` = `pc_in` and `sp_next` = `sp_in`.
- R7: A restart (`op`=3) always pushes `pc_in` as in R4, whatever `cond_en` is. It finishes with `pc_next` = `cond` × 8 and `sp_next` = SP-2.
- R8: A jump through HL (`op`=4) finishes one cycle after `start` with `pc_next` = `hl`, makes no stack access and leaves SP unchanged. The codes 5 to 7 finish in one cycle with `pc_next` = `pc_in`.
- R9: A `start` that arrives while `busy` is high is ignored. The running operation completes unchanged, with one `done` pulse.
- R10: `mem_wr` and `mem_rd` are never high together. `done` is a single-cycle pulse that is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| op | input | 3 | Transfer kind: 0 jump, 1 call, 2 return, 3 restart, 4 jump via HL |
| cond_en | input | 1 | 1 makes jump, call or return conditional |
| cond | input | 3 | Condition code, or restart number |
| flag_z | input | 1 | Zero flag |
| flag_cy | input | 1 | Carry flag |
| flag_p | input | 1 | Parity flag (1 = even) |
| flag_s | input | 1 | Sign flag |
| target | input | 16 | Target address from the instruction |
| hl | input | 16 | HL register pair |
| pc_in | input | 16 | Address of the following instruction |
| sp_in | input | 16 | Current stack pointer |
| busy | output | 1 | Stack sequence in progress |
| done | output | 1 | One-cycle strobe: pc_next and sp_next valid |
| pc_next | output | 16 | New program counter |
| sp_next | output | 16 | New stack pointer |
| mem_addr | output | 16 | Stack memory address |
| mem_wr | output | 1 | Stack byte write strobe |
| mem_wdata | output | 8 | Stack write byte |
| mem_rd | output | 1 | Stack byte read strobe |
| mem_rdata | input | 8 | Stack read byte, valid in the cycle of mem_rd |

## Verification
Single-step results (jumps, jumps via HL, failed conditions) are due on the first clock edge after `start`. Stack results are due on the third edge: two edges carry the two byte accesses and the third carries the final update. The bench drives `start` on a falling edge and counts falling edges until `done` appears, so each case checks both the value and the exact latency. It also logs every stack access on the rising edge, to check the address order, the byte order, and that no access happens on paths that must stay off the stack.

// File: rtl/pc_branch_unit.sv
module pc_branch_unit #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              cond_en,
  input  logic [2:0]        cond,
  input  logic              flag_z,
  input  logic              flag_cy,
  input  logic              flag_p,
  input  logic              flag_s,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] hl,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pc_next,
  output logic [ADDR_W-1:0] sp_next,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [2:0] OP_JMP  = 3'd0;
  localparam logic [2:0] OP_CALL = 3'd1;
  localparam logic [2:0] OP_RET  = 3'd2;
  localparam logic [2:0] OP_RST  = 3'd3;
  localparam logic [2:0] OP_PCHL = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_PUSH_HI, S_PUSH_LO, S_POP_LO, S_POP_HI} state_t;

  state_t            state;
  logic [ADDR_W-1:0] sp_r, ret_r, dest_r;
  logic [7:0]        lo_r;
  logic              flag_sel, cond_true, taken, idle_start;

  always_comb begin
    case (cond[2:1])
      2'b00:   flag_sel = flag_z;
      2'b01:   flag_sel = flag_cy;
      2'b10:   flag_sel = flag_p;
      default: flag_sel = flag_s;
    endcase
  end

  assign cond_true  = (flag_sel == cond[0]);
  assign taken      = !cond_en || cond_true;
  assign idle_start = (state == S_IDLE) && start;

  assign busy      = (state != S_IDLE);
  assign mem_addr  = sp_r;
  assign mem_wr    = (state == S_PUSH_HI) || (state == S_PUSH_LO);
  assign mem_rd    = (state == S_POP_LO) || (state == S_POP_HI);
  assign mem_wdata = (state == S_PUSH_HI) ? ret_r[ADDR_W-1:ADDR_W-8] : ret_r[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      pc_next <= '0;
      sp_next <= '0;
      sp_r    <= '0;
      ret_r   <= '0;
      dest_r  <= '0;
      lo_r    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          case (op)
            OP_JMP: begin
              done    <= 1'b1;
              pc_next <= taken ? target : pc_in;
              sp_next <= sp_in;
            end
            OP_CALL, OP_RST: begin
              if (op == OP_RST || taken) begin
                ret_r  <= pc_in;
                dest_r <= (op == OP_RST) ? {{(ADDR_W-6){1'b0}}, cond, 3'b000} : target;
                sp_r   <= sp_in - 1'b1;
                state  <= S_PUSH_HI;
              end else begin
                done    <= 1'b1;
                pc_next <= pc_in;
                sp_next <= sp_in;
              end
            end
            OP_RET: begin
              if (taken) begin
                sp_r  <= sp_in;
                state <= S_POP_LO;
              end else begin
                done    <= 1'b1;
                pc_next <= pc_in;
                sp_next <= sp_in;
              end
            end
            OP_PCHL: begin
              done    <= 1'b1;
              pc_next <= hl;
              sp_next <= sp_in;
            end
            default: begin
              done    <= 1'b1;
              pc_next <= pc_in;
              sp_next <= sp_in;
            end
          endcase
        end
        S_PUSH_HI: begin
          sp_r  <= sp_r - 1'b1;
          state <= S_PUSH_LO;
        end
        S_PUSH_LO: begin
          done    <= 1'b1;
          pc_next <= dest_r;
          sp_next <= sp_r;
          state   <= S_IDLE;
        end
        S_POP_LO: begin
          lo_r  <= mem_rdata;
          sp_r  <= sp_r + 1'b1;
          state <= S_POP_HI;
        end
        S_POP_HI: begin
          done    <= 1'b1;
          pc_next <= {mem_rdata[HI_W-1:0], lo_r};
          sp_next <= sp_r + 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_rw_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_push_hi_then_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PUSH_HI) |=> (mem_wr && mem_addr == $past(mem_addr) - 1'b1));

  assert_pop_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POP_HI) |=> (done && sp_next == $past(mem_addr) + 1'b1));

  assert_not_taken_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_start && cond_en && !cond_true && (op == OP_JMP || op == OP_CALL || op == OP_RET))
    |=> (done && pc_next == $past(pc_in) && !mem_wr && !mem_rd));
endmodule

// File: tb/sim_pc_branch_unit.sv
module sim_pc_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0, cond = '0;
  logic        cond_en = 1'b0;
  logic        fz = 1'b0, fcy = 1'b0, fp = 1'b0, fs = 1'b0;
  logic [15:0] target = 16'h1234, hl = 16'hBEEF, pc_in = 16'h0103, sp_in = 16'h00F0;
  logic        busy, done, mem_wr, mem_rd;
  logic [15:0] pc_next, sp_next, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, both_cnt = 0, done_cnt = 0;
  logic [15:0] first_wa, first_ra;
  logic [7:0]  first_wd;
  logic [7:0]  mem [256];

  always #2.5 clk = ~clk;

  pc_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond_en(cond_en), .cond(cond),
    .flag_z(fz), .flag_cy(fcy), .flag_p(fp), .flag_s(fs),
    .target(target), .hl(hl), .pc_in(pc_in), .sp_in(sp_in),
    .busy(busy), .done(done), .pc_next(pc_next), .sp_next(sp_next),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_wr) begin
      if (wr_cnt == 0) begin first_wa <= mem_addr; first_wd <= mem_wdata; end
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_rd) begin
      if (rd_cnt == 0) first_ra <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_wr && mem_rd) both_cnt <= both_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic ce, input logic [2:0] c,
                        input logic [3:0] fl, output int cyc);
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; done_cnt = 0;
    op = o; cond_en = ce; cond = c;
    {fs, fp, fcy, fz} = fl;
    start = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end while (!done && cyc < 10);
  endtask

  function automatic logic cond_expect(input logic [2:0] c, input logic [3:0] fl);
    case (c)
      3'd0: return !fl[0];
      3'd1: return  fl[0];
      3'd2: return !fl[1];
      3'd3: return  fl[1];
      3'd4: return !fl[2];
      3'd5: return  fl[2];
      3'd6: return !fl[3];
      default: return fl[3];
    endcase
  endfunction

  typedef struct packed {
    logic [2:0]  o;
    logic        ce;
    logic [2:0]  c;
    logic [3:0]  fl;
    logic [15:0] pc;
    logic [15:0] sp;
    logic [3:0]  cyc;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd0, 1'b0, 3'd0, 4'h0, 16'h1234, 16'h00F0, 4'd1},
    '{3'd1, 1'b0, 3'd0, 4'h0, 16'h1234, 16'h00EE, 4'd3},
    '{3'd2, 1'b0, 3'd0, 4'h0, 16'h5678, 16'h00F2, 4'd3},
    '{3'd3, 1'b0, 3'd5, 4'h0, 16'h0028, 16'h00EE, 4'd3},
    '{3'd4, 1'b0, 3'd0, 4'h0, 16'hBEEF, 16'h00F0, 4'd1},
    '{3'd1, 1'b1, 3'd0, 4'h1, 16'h0103, 16'h00F0, 4'd1},
    '{3'd2, 1'b1, 3'd3, 4'h2, 16'h5678, 16'h00F2, 4'd3},
    '{3'd3, 1'b1, 3'd7, 4'h0, 16'h0038, 16'h00EE, 4'd3}
  };

  initial begin
    int cyc;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'hF0] = 8'h78;
    mem[8'hF1] = 8'h56;
    repeat (3) @(negedge clk);
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    check("R1 mem strobes", {mem_wr, mem_rd}, 0);
    check("R1 pc_next", pc_next, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {done, busy, mem_wr, mem_rd, sp_next}, 0);

    // R3 R4 R5 R6 R7 R8: table of directed vectors
    for (int i = 0; i < 8; i++) begin
      run_op(VEC[i].o, VEC[i].ce, VEC[i].c, VEC[i].fl, cyc);
      check($sformatf("R3-8 vec%0d pc", i), pc_next, VEC[i].pc);
      check($sformatf("R3-8 vec%0d sp", i), sp_next, VEC[i].sp);
      check($sformatf("R3-8 vec%0d latency", i), cyc, VEC[i].cyc);
      if (VEC[i].cyc == 1) check("R6 R8 no stack access", wr_cnt + rd_cnt, 0);
      if (VEC[i].o == 3'd1 && VEC[i].cyc == 3) begin
        check("R4 first write addr", first_wa, 16'h00EF);
        check("R4 first write data", first_wd, 8'h01);
        check("R4 low byte stored", mem[8'hEE], 8'h03);
        check("R4 write count", wr_cnt, 2);
      end
      if (VEC[i].o == 3'd2 && VEC[i].cyc == 3) begin
        check("R5 first read addr", first_ra, 16'h00F0);
        check("R5 read count", rd_cnt, 2);
      end
    end

    // R2 R3: every condition code against every flag combination
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic t;
        t = cond_expect(3'(c), 4'(f));
        run_op(3'd0, 1'b1, 3'(c), 4'(f), cyc);
        check($sformatf("R2 cond %0d flags %h", c, f), pc_next, t ? 16'h1234 : 16'h0103);
        check("R3 jump latency", cyc, 1);
      end
    end

    // R9: a second start during a call is dropped
    @(negedge clk);
    done_cnt = 0;
    op = 3'd1; cond_en = 1'b0; start = 1'b1;
    @(negedge clk);
    op = 3'd4; target = 16'h4444;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 call result kept", pc_next, 16'h1234);
    check("R9 single done", done_cnt, 1);
    check("R9 sp", sp_next, 16'h00EE);
    target = 16'h1234;

    // R10: a done pulse lasts one cycle, no read/write overlap seen
    run_op(3'd1, 1'b0, 3'd0, 4'h0, cyc);
    @(negedge clk);
    check("R10 done pulse width", done, 0);
    check("R10 rw overlap", both_cnt, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule